// File: doc/BRIEF.md
# Register-Driven Block Copy Engine

This engine carries out memory-to-memory copies described by three register values: a transfer count, a source pointer and a destination pointer. A start pulse loads those values together with a mode and a unit size. The engine then alternates single-port memory reads and writes until the copy is complete. When it finishes it raises a one-cycle done pulse, and the updated pointers and count are available as the values to write back to the register file.

There are three modes.

- **Block move.** Copies a fixed number of byte, word or longword units. The remaining count is written back after every unit.
- **String copy.** Copies single bytes and stops early once a zero byte has been written. In that case it raises a branch-taken flag, so a surrounding sequencer can redirect its program counter.
- **Truncated-count byte move.** Takes its count from a narrow field, moves that many bytes, clears only that field at the end, and reports a cost of two cycles per byte.

Instruction decode, the register file and bus arbitration are outside the block.

Top module: `blockcopy_engine`

## Requirements
- R1: After synchronous active-high reset the engine is idle: `busy`, `done`, `memReq`, `cntWr` and `branchTaken` are low.
- R2: Each unit is read at the current source pointer and written unchanged at the current destination pointer. Both pointers then advance by the unit size. `sizeSel` encodes the unit: 0 is a byte (advance 1), 1 is a word (advance 2), and 2 or 3 is a longword (advance 4). Data sits in the low bits of the 32-bit data buses.
- R3: In block and string modes, `cntWr` pulses after every unit. With that pulse, the low `CountWidth` bits of `cntOut` hold the number of units still to move, and the upper bits keep their loaded value. After a full run the field is zero.
- R4: In block and string modes, a count field of zero means 2^`CountWidth` transfers.
- R5: In string mode (`modeSel` = 1), units are single bytes. After a byte of value zero has been written, the engine stops and `branchTaken` goes high in the same cycle as `done`.
- R6: In string mode, if every counted byte moves without a zero byte, `branchTaken` stays low.
- R7: In truncated mode (`modeSel` = 2), the count is `cntIn[7:0]` when `sizeSel` is 0, and the low `CountWidth` bits otherwise. Units are single bytes and both pointers advance by that count. At the end only that field is cleared, with one `cntWr` pulse.
- R8: In truncated mode, `cost` equals twice the byte count. In the other modes it is zero.
- R9: `done` is high for exactly one cycle per operation. At that point `srcOut`, `dstOut`, `cntOut` and `branchTaken` hold the final values, and `busy` is high from start until done.
- R10: Each access keeps `memReq`, `memWe` and `memAddr` steady until `memValid`. The write of a unit is issued only after its read has completed.
- R11: In truncated mode a zero count field performs no memory access. The engine signals done with the pointers and the count unchanged.
- R12: Mode code 3 behaves as block move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| modeSel | input | 2 | 0 block, 1 string, 2 truncated, 3 block |
| sizeSel | input | 2 | 0 byte, 1 word, 2/3 longword |
| cntIn | input | RegWidth | Count register value |
| srcIn | input | AddrWidth | Source pointer value |
| dstIn | input | AddrWidth | Destination pointer value |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | AddrWidth | Access address |
| memSize | output | 2 | Unit code of the access |
| memWdata | output | 32 | Write data, low bits significant |
| memRdata | input | 32 | Read data, low bits significant |
| memValid | input | 1 | Access completed this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| branchTaken | output | 1 | String copy ended on a zero byte |
| cntWr | output | 1 | Count register write-back strobe |
| cntOut | output | RegWidth | Count register value to write back |
| srcOut | output | AddrWidth | Source pointer value |
| dstOut | output | AddrWidth | Destination pointer value |
| cost | output | RegWidth | Reported cycle cost of a truncated move |

## Verification
Several properties are checked on every cycle:

- an idle engine never requests memory;
- a request holds its address until it completes;
- every write follows a completed read;
- each unit step moves the source pointer by the unit size;
- each write-back strobe carries the remaining count;
- a truncated move strobes only once its count is exhausted;
- done lasts one cycle, and branch-taken rises only with done.

Only the directed scenarios can show the rest. This covers data integrity across unit sizes and wait states, the 2^CountWidth run from a zero count, early termination on a zero byte against a full string run, field truncation and clearing in both truncated forms, the cost value, and the zero-count truncated case.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'd0,
    MODE_STRING = 2'd1,
    MODE_TRUNC  = 2'd2,
    MODE_ALT    = 2'd3
  } modeE;

  localparam logic [1:0] UNIT_BYTE = 2'd0;
  localparam logic [1:0] UNIT_WORD = 2'd1;
  localparam logic [1:0] UNIT_LONG = 2'd2;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic capture;
    logic step;
    logic finish;
    logic setBranch;
  } strobeT;

  function automatic logic [2:0] unitBytes(input logic [1:0] unitCode);
    case (unitCode)
      UNIT_BYTE: unitBytes = 3'd1;
      UNIT_WORD: unitBytes = 3'd2;
      default:   unitBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bce_datapath.sv
module bce_datapath
  import bce_pkg::*;
#(
  parameter int AddrWidth  = 32,
  parameter int RegWidth   = 32,
  parameter int CountWidth = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobeT               strobe,
  input  logic [1:0]           modeSel,
  input  logic [1:0]           sizeSel,
  input  logic [RegWidth-1:0]  cntIn,
  input  logic [AddrWidth-1:0] srcIn,
  input  logic [AddrWidth-1:0] dstIn,
  input  logic [31:0]          memRdata,
  output logic [AddrWidth-1:0] srcPtr,
  output logic [AddrWidth-1:0] dstPtr,
  output logic [RegWidth-1:0]  cntReg,
  output logic [31:0]          dataBuf,
  output logic [1:0]           unitCode,
  output logic                 remainZero,
  output logic                 lastUnit,
  output logic                 dataZero,
  output logic                 isString,
  output logic                 branchFlag,
  output logic                 cntWrPulse,
  output logic [RegWidth-1:0]  costReg
);

  localparam int RemWidth = CountWidth + 1;
  localparam logic [RemWidth-1:0] FullCount = RemWidth'(1) << CountWidth;

  logic [RemWidth-1:0]   remain;
  logic [RemWidth-1:0]   loadRemain;
  logic [CountWidth-1:0] blkField;
  logic [RemWidth-1:0]   truncField;
  logic                  truncWord;
  modeE                  modeR;
  modeE                  modeNew;
  logic                  isTrunc;
  logic [AddrWidth-1:0]  stepInc;

  assign modeNew  = modeE'(modeSel);
  assign blkField = cntIn[CountWidth-1:0];

  always_comb begin
    truncField = (sizeSel == UNIT_BYTE) ? RemWidth'(cntIn[7:0]) : {1'b0, blkField};
    if (modeNew == MODE_TRUNC)
      loadRemain = truncField;
    else if (blkField == '0)
      loadRemain = FullCount;
    else
      loadRemain = {1'b0, blkField};
  end

  assign isTrunc    = (modeR == MODE_TRUNC);
  assign isString   = (modeR == MODE_STRING);
  assign remainZero = (remain == '0);
  assign lastUnit   = (remain == RemWidth'(1));
  assign dataZero   = (dataBuf[7:0] == 8'h00);
  assign stepInc    = AddrWidth'(unitBytes(unitCode));

  always_ff @(posedge clk) begin
    if (rst) begin
      srcPtr     <= '0;
      dstPtr     <= '0;
      cntReg     <= '0;
      dataBuf    <= '0;
      unitCode   <= UNIT_BYTE;
      remain     <= '0;
      truncWord  <= 1'b0;
      modeR      <= MODE_BLOCK;
      branchFlag <= 1'b0;
      cntWrPulse <= 1'b0;
      costReg    <= '0;
    end else begin
      cntWrPulse <= 1'b0;
      if (strobe.load) begin
        srcPtr     <= srcIn;
        dstPtr     <= dstIn;
        cntReg     <= cntIn;
        modeR      <= modeNew;
        unitCode   <= (modeNew == MODE_STRING || modeNew == MODE_TRUNC) ? UNIT_BYTE : sizeSel;
        truncWord  <= (sizeSel != UNIT_BYTE);
        remain     <= loadRemain;
        branchFlag <= 1'b0;
        costReg    <= (modeNew == MODE_TRUNC) ? RegWidth'(truncField) << 1 : '0;
      end
      if (strobe.capture)
        dataBuf <= memRdata;
      if (strobe.step) begin
        srcPtr <= srcPtr + stepInc;
        dstPtr <= dstPtr + stepInc;
        remain <= remain - RemWidth'(1);
        if (!isTrunc) begin
          cntReg[CountWidth-1:0] <= CountWidth'(remain - RemWidth'(1));
          cntWrPulse             <= 1'b1;
        end
      end
      if (strobe.finish && isTrunc) begin
        if (truncWord) cntReg[CountWidth-1:0] <= '0;
        else           cntReg[7:0]            <= '0;
        cntWrPulse <= 1'b1;
      end
      if (strobe.setBranch)
        branchFlag <= 1'b1;
    end
  end

  // R2: every unit step moves the source pointer by exactly the unit size
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> srcPtr == $past(srcPtr) + AddrWidth'(unitBytes($past(unitCode))));

  // R3: each write-back strobe in block or string mode carries the remaining count
  assert_cnt_tracks_remain_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !isTrunc) |=> cntWrPulse && cntReg[CountWidth-1:0] == CountWidth'(remain));

  // R7: a truncated move strobes the count only after its count is exhausted
  assert_trunc_late_write_R7: assert property (@(posedge clk) disable iff (rst)
    (cntWrPulse && isTrunc) |-> remainZero);

endmodule

// File: rtl/bce_control.sv
module bce_control
  import bce_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   memValid,
  input  logic   remainZero,
  input  logic   lastUnit,
  input  logic   dataZero,
  input  logic   isString,
  output strobeT strobe,
  output logic   memReq,
  output logic   memWe,
  output logic   busy,
  output logic   done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_FIN
  } stateE;

  stateE state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = ST_CHECK;
      end
      ST_CHECK: if (remainZero) begin
        strobe.finish = 1'b1;
        stateNext     = ST_FIN;
      end else begin
        stateNext = ST_READ;
      end
      ST_READ: if (memValid) begin
        strobe.capture = 1'b1;
        stateNext      = ST_WRITE;
      end
      ST_WRITE: if (memValid) begin
        strobe.step = 1'b1;
        if (isString && dataZero) begin
          strobe.setBranch = 1'b1;
          strobe.finish    = 1'b1;
          stateNext        = ST_FIN;
        end else if (lastUnit) begin
          strobe.finish = 1'b1;
          stateNext     = ST_FIN;
        end else begin
          stateNext = ST_READ;
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);

  // R1: an idle engine never requests memory
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !memReq);

  // R9: done lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a write request only begins after a read has completed
  assert_write_after_read_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(memWe) |-> $past(memValid));

endmodule

// File: rtl/blockcopy_engine.sv
module blockcopy_engine
  import bce_pkg::*;
#(
  parameter int AddrWidth  = 32,
  parameter int RegWidth   = 32,
  parameter int CountWidth = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           modeSel,
  input  logic [1:0]           sizeSel,
  input  logic [RegWidth-1:0]  cntIn,
  input  logic [AddrWidth-1:0] srcIn,
  input  logic [AddrWidth-1:0] dstIn,
  output logic                 memReq,
  output logic                 memWe,
  output logic [AddrWidth-1:0] memAddr,
  output logic [1:0]           memSize,
  output logic [31:0]          memWdata,
  input  logic [31:0]          memRdata,
  input  logic                 memValid,
  output logic                 busy,
  output logic                 done,
  output logic                 branchTaken,
  output logic                 cntWr,
  output logic [RegWidth-1:0]  cntOut,
  output logic [AddrWidth-1:0] srcOut,
  output logic [AddrWidth-1:0] dstOut,
  output logic [RegWidth-1:0]  cost
);

  strobeT     strobe;
  logic       remainZero;
  logic       lastUnit;
  logic       dataZero;
  logic       isString;
  logic [31:0] dataBuf;

  bce_control u_control (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .memValid   (memValid),
    .remainZero (remainZero),
    .lastUnit   (lastUnit),
    .dataZero   (dataZero),
    .isString   (isString),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy),
    .done       (done)
  );

  bce_datapath #(
    .AddrWidth  (AddrWidth),
    .RegWidth   (RegWidth),
    .CountWidth (CountWidth)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .modeSel    (modeSel),
    .sizeSel    (sizeSel),
    .cntIn      (cntIn),
    .srcIn      (srcIn),
    .dstIn      (dstIn),
    .memRdata   (memRdata),
    .srcPtr     (srcOut),
    .dstPtr     (dstOut),
    .cntReg     (cntOut),
    .dataBuf    (dataBuf),
    .unitCode   (memSize),
    .remainZero (remainZero),
    .lastUnit   (lastUnit),
    .dataZero   (dataZero),
    .isString   (isString),
    .branchFlag (branchTaken),
    .cntWrPulse (cntWr),
    .costReg    (cost)
  );

  assign memAddr  = memWe ? dstOut : srcOut;
  assign memWdata = dataBuf;

  // R10: a pending access keeps its address and direction until it completes
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memValid) |=> memReq && $stable(memWe) && $stable(memAddr));

  // R5: branch-taken is raised together with the done pulse
  assert_branch_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(branchTaken) |-> done);

endmodule

// File: tb/test_blockcopy_engine.sv
module test_blockcopy_engine;

  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [1:0]  sizeSel = 2'd0;
  logic [31:0] cntIn = '0, srcIn = '0, dstIn = '0;
  logic        memReq, memWe, memValid;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;
  logic        busy, done, branchTaken, cntWr;
  logic [31:0] cntOut, srcOut, dstOut, cost;

  always #2 clk = ~clk;

  blockcopy_engine #(.AddrWidth(32), .RegWidth(32), .CountWidth(CW)) i_blockcopy_engine (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel), .sizeSel(sizeSel),
    .cntIn(cntIn), .srcIn(srcIn), .dstIn(dstIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memValid(memValid),
    .busy(busy), .done(done), .branchTaken(branchTaken), .cntWr(cntWr),
    .cntOut(cntOut), .srcOut(srcOut), .dstOut(dstOut), .cost(cost)
  );

  // bench memory: 64 KiB, little-endian
  logic [7:0] mem [65536];
  int latency = 0, waitCnt = 0;
  int nReads = 0, nWrites = 0, orderErr = 0;
  bit lastRead = 1'b0;
  int nCntWr = 0, seqErr = 0, expRem = 0, doneCycles = 0;
  bit seqCheck = 1'b0;
  logic [31:0] upperExp = '0;
  int cycles = 0;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      memValid <= 1'b0;
      memRdata <= '0;
      waitCnt  <= 0;
    end else if (memValid) begin
      memValid <= 1'b0;
    end else if (memReq) begin
      if (waitCnt < latency) waitCnt <= waitCnt + 1;
      else begin
        waitCnt  <= 0;
        memValid <= 1'b1;
        if (memWe) begin
          for (int i = 0; i < (memSize == 2'd0 ? 1 : memSize == 2'd1 ? 2 : 4); i++)
            mem[16'(memAddr + 32'(i))] <= memWdata[8*i +: 8];
          nWrites <= nWrites + 1;
          if (!lastRead) orderErr <= orderErr + 1;
          lastRead <= 1'b0;
        end else begin
          memRdata <= '0;
          for (int i = 0; i < (memSize == 2'd0 ? 1 : memSize == 2'd1 ? 2 : 4); i++)
            memRdata[8*i +: 8] <= mem[16'(memAddr + 32'(i))];
          nReads   <= nReads + 1;
          lastRead <= 1'b1;
        end
      end
    end
    if (!rst && done) doneCycles <= doneCycles + 1;
    if (!rst && cntWr) begin
      nCntWr <= nCntWr + 1;
      if (seqCheck) begin
        if (cntOut[CW-1:0] != CW'(expRem - 1) || cntOut[31:CW] != upperExp[31:CW])
          seqErr <= seqErr + 1;
        expRem <= expRem - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic runOp(input logic [1:0] m, input logic [1:0] sz, input logic [31:0] c,
                       input logic [31:0] s, input logic [31:0] d, input int lat, input int units);
    @(negedge clk);
    latency = lat;
    nReads = 0; nWrites = 0; orderErr = 0; nCntWr = 0; seqErr = 0; doneCycles = 0;
    expRem = units; upperExp = c; seqCheck = (m != 2'd2);
    modeSel = m; sizeSel = sz; cntIn = c; srcIn = s; dstIn = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9 busy after start", 32'(busy), 32'd1);
    while (!done) begin
      @(negedge clk);
      if (cycles > 150000) begin
        check(1'b0, "watchdog", 32'(cycles), 32'd0);
        finishRun();
      end
    end
    @(negedge clk);
    @(negedge clk);
    check(doneCycles == 1, "R9 done width", 32'(doneCycles), 32'd1);
    check(orderErr == 0, "R10 read before write", 32'(orderErr), 32'd0);
  endtask

  task automatic fill(input logic [31:0] base, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[16'(base + 32'(i))] = 8'((i * 7 + seed) % 251 + 1);
  endtask

  function automatic bit sameBytes(input logic [31:0] a, input logic [31:0] b, input int n);
    for (int i = 0; i < n; i++)
      if (mem[16'(a + 32'(i))] !== mem[16'(b + 32'(i))]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic testReset();
    check(!busy && !done && !memReq && !cntWr && !branchTaken, "R1 reset idle",
          {27'd0, busy, done, memReq, cntWr, branchTaken}, 32'd0);
  endtask

  task automatic testBlock(input logic [1:0] sz, input int n, input int lat, input logic [1:0] m, input string tag);
    int ub = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    fill(32'h0200, n * ub, n);
    for (int i = 0; i < n * ub; i++) mem[16'(32'h0600 + 32'(i))] = 8'h00;
    runOp(m, sz, 32'hABCD0000 | 32'(n), 32'h0200, 32'h0600, lat, n);
    check(sameBytes(32'h0200, 32'h0600, n * ub), {tag, " R2 data copied"}, 32'd0, 32'd0);
    check(srcOut == 32'h0200 + 32'(n * ub), {tag, " R2 src advance"}, srcOut, 32'h0200 + 32'(n * ub));
    check(dstOut == 32'h0600 + 32'(n * ub), {tag, " R2 dst advance"}, dstOut, 32'h0600 + 32'(n * ub));
    check(cntOut == 32'hABCD0000, {tag, " R3 final count"}, cntOut, 32'hABCD0000);
    check(nCntWr == n && seqErr == 0, {tag, " R3 per-unit writeback"}, 32'(nCntWr), 32'(n));
    check(nReads == n && nWrites == n, {tag, " R10 access count"}, 32'(nReads), 32'(n));
    check(cost == 0, {tag, " R8 no cost outside truncated"}, cost, 32'd0);
  endtask

  task automatic testZeroCount();
    fill(32'h1000, 4096, 3);
    runOp(2'd0, 2'd0, 32'h55550000, 32'h1000, 32'h4000, 0, 4096);
    check(srcOut == 32'h2000 && dstOut == 32'h5000, "R4 zero count is full range", srcOut, 32'h2000);
    check(nCntWr == 4096 && seqErr == 0, "R4 unit count", 32'(nCntWr), 32'd4096);
    check(cntOut == 32'h55550000, "R4 final count", cntOut, 32'h55550000);
    check(sameBytes(32'h1000, 32'h4000, 4096), "R4 data copied", 32'd0, 32'd0);
  endtask

  task automatic testStringZero();
    mem[16'h0800] = 8'h41; mem[16'h0801] = 8'h42; mem[16'h0802] = 8'h43;
    mem[16'h0803] = 8'h00; mem[16'h0804] = 8'h58; mem[16'h0805] = 8'h59;
    for (int i = 0; i < 8; i++) mem[16'(32'h0900 + 32'(i))] = 8'hEE;
    runOp(2'd1, 2'd2, 32'h0000000A, 32'h0800, 32'h0900, 1, 10);
    check(branchTaken, "R5 branch taken on zero byte", 32'(branchTaken), 32'd1);
    check(nWrites == 4, "R5 stops after zero byte", 32'(nWrites), 32'd4);
    check(mem[16'h0903] == 8'h00 && mem[16'h0904] == 8'hEE, "R5 nothing past terminator",
          {16'd0, mem[16'h0903], mem[16'h0904]}, 32'h000000EE);
    check(cntOut == 32'h6 && srcOut == 32'h0804 && dstOut == 32'h0904, "R5 partial count",
          cntOut, 32'h6);
    check(nCntWr == 4 && seqErr == 0, "R3 string writeback", 32'(nCntWr), 32'd4);
  endtask

  task automatic testStringFull();
    fill(32'h0A00, 5, 9);
    runOp(2'd1, 2'd1, 32'h00000005, 32'h0A00, 32'h0B00, 0, 5);
    check(!branchTaken, "R6 no branch without zero", 32'(branchTaken), 32'd0);
    check(sameBytes(32'h0A00, 32'h0B00, 5) && nWrites == 5, "R6 all bytes moved", 32'(nWrites), 32'd5);
    check(srcOut == 32'h0A05 && cntOut == 32'h0, "R5 byte units in string mode", srcOut, 32'h0A05);
  endtask

  task automatic testTrunc(input logic [1:0] sz, input logic [31:0] c, input int n, input logic [31:0] cExp);
    fill(32'h2000, n, 5);
    runOp(2'd2, sz, c, 32'h2000, 32'h3000, 0, n);
    check(srcOut == 32'h2000 + 32'(n) && dstOut == 32'h3000 + 32'(n), "R7 pointers advance by count",
          srcOut, 32'h2000 + 32'(n));
    check(cntOut == cExp, "R7 only field cleared", cntOut, cExp);
    check(nCntWr == 1, "R7 single writeback", 32'(nCntWr), 32'd1);
    check(sameBytes(32'h2000, 32'h3000, n) && nWrites == n, "R7 bytes moved", 32'(nWrites), 32'(n));
    check(cost == 32'(2 * n), "R8 cost two per byte", cost, 32'(2 * n));
  endtask

  task automatic testTruncZero();
    runOp(2'd2, 2'd0, 32'h00000F00, 32'h2100, 32'h3100, 0, 0);
    check(nReads == 0 && nWrites == 0, "R11 no access", 32'(nReads + nWrites), 32'd0);
    check(srcOut == 32'h2100 && dstOut == 32'h3100 && cntOut == 32'h0F00, "R11 state unchanged",
          cntOut, 32'h0F00);
    check(cost == 0, "R8 zero cost", cost, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testBlock(2'd0, 9, 0, 2'd0, "byte");
    testBlock(2'd1, 7, 2, 2'd0, "word");
    testBlock(2'd2, 5, 2, 2'd0, "long");
    testBlock(2'd3, 3, 1, 2'd0, "long3");
    testBlock(2'd1, 4, 0, 2'd3, "R12 mode3");
    testZeroCount();
    testStringZero();
    testStringFull();
    testTrunc(2'd0, 32'hABCD1234, 52, 32'hABCD1200);
    testTrunc(2'd1, 32'hABCD1234, 564, 32'hABCD1000);
    testTruncZero();
    @(negedge clk);
    testReset();
    finishRun();
  end

endmodule